// File: doc/BRIEF.md
# Reaction Timer Controller

This block measures how long a person takes to react to a lit LED. The measurement is in hundredths of a second. A free-running power-of-two prescaler divides the 102.4 kHz input clock by 1024, which gives a one-cycle pulse at 100 Hz. A one-bit run flop drives the LED. While that flop is set, each pulse advances a two-digit BCD counter by one.

A test sequence has four steps:

1. Reset clears everything.
2. A one-cycle pulse on `arm` lights the LED and starts the count.
3. Pressing the active-low push button turns the LED off and freezes the count.
4. The frozen count stays on the two digit outputs until the next reset.

Seven-segment decoding and switch debouncing belong to the surrounding logic.

Top module: `rxn_timer`

## Requirements
- R1: When `rst` is high at a clock edge, `led` becomes 0 and both digits become 0 after that edge.
- R2: With the LED off and no measurement finished since reset, `arm` high at an edge sets `led` to 1 after that edge.
- R3: The prescaler produces a one-cycle tick every 2^PRESCALE_W cycles. The first tick is high in the cycle after edge number 2^PRESCALE_W counted from reset release. Each tick seen while the LED is on raises the count by exactly one at the next edge.
- R4: While `led` is 0, the digits do not change.
- R5: `btn_n` low (pressed) at an edge while `led` is 1 clears `led` after that edge. The count then holds until reset.
- R6: `btn_n` low while `led` is 0 has no effect on `led` or the digits.
- R7: At a count of 99 (`digit_hi`=9, `digit_lo`=9), further ticks leave the count at 99. The count does not wrap.
- R8: Each digit is a BCD value from 0 to 9. When the low digit steps from 9, it returns to 0 and the high digit steps by one.
- R9: After a press has stopped a measurement, `arm` is ignored until the next reset. The LED stays off and the count stays frozen.
- R10: A tick in the same cycle as the stopping press is still counted, because counting uses the run state from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 102.4 kHz clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start pulse; lights the LED and begins counting |
| btn_n | input | 1 | Push button, 1 when idle and 0 when pressed |
| led | output | 1 | LED drive, high while the measurement runs |
| digit_hi | output | 4 | Tens of hundredths, BCD |
| digit_lo | output | 4 | Hundredths, BCD |

## Verification
- **LED changes:** `arm` or a press at an edge changes `led` right after that same edge, so the LED is sampled at the following falling edge.
- **Tick-driven count:** a tick becomes visible one cycle after the prescaler rolls over. The count moves at the edge after that, so a count change lags the rollover by two edges.
- **Reference model:** the bench keeps its own edge counter from reset release. It advances an integer model at every rising edge, using the input values from before that edge.
- **Sampling:** inputs are driven and outputs compared only at falling edges. Every comparison therefore sees the state after all earlier edges.

// File: rtl/rxn_pkg.sv
package rxn_pkg;

    localparam int BCD_W     = 4;
    localparam int N_DIGITS  = 2;
    localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t hi;
        bcd_t lo;
    } bcd_pair_t;

    typedef enum logic {
        RUN_OFF = 1'b0,
        RUN_ON  = 1'b1
    } run_t;

    function automatic bcd_t bcd_next(input bcd_t d);
        return (d == BCD_MAX) ? bcd_t'(0) : bcd_t'(d + 1'b1);
    endfunction

    function automatic logic bcd_full(input bcd_t d);
        return d == BCD_MAX;
    endfunction

endpackage

// File: rtl/rxn_prescaler.sv
module rxn_prescaler #(
    parameter int PRESCALE_W = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [PRESCALE_W-1:0] TOP = {PRESCALE_W{1'b1}};

    logic [PRESCALE_W-1:0] div_q;
    logic                  tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_q <= (div_q == TOP);
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/rxn_run_ctrl.sv
module rxn_run_ctrl
    import rxn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic press,
    output run_t run
);
    run_t run_q;
    logic spent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= RUN_OFF;
            spent_q <= 1'b0;
        end else if (run_q == RUN_ON) begin
            if (press) begin
                run_q   <= RUN_OFF;
                spent_q <= 1'b1;
            end
        end else if (start && !spent_q) begin
            run_q <= RUN_ON;
        end
    end

    assign run = run_q;
endmodule

// File: rtl/rxn_bcd_counter.sv
module rxn_bcd_counter
    import rxn_pkg::*;
#(
    parameter int DIGITS = N_DIGITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step,
    output logic [DIGITS-1:0][BCD_W-1:0] value
);
    logic [DIGITS-1:0][BCD_W-1:0] dig_q;
    logic [DIGITS:0]              carry;
    logic                         all_full;

    always_comb begin
        all_full = 1'b1;
        for (int k = 0; k < DIGITS; k++) begin
            all_full = all_full & bcd_full(dig_q[k]);
        end
    end

    assign carry[0] = step & ~all_full;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        assign carry[i+1] = carry[i] & bcd_full(dig_q[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                dig_q[i] <= '0;
            end else if (carry[i]) begin
                dig_q[i] <= bcd_next(dig_q[i]);
            end
        end
    end

    assign value = dig_q;
endmodule

// File: rtl/rxn_timer.sv
module rxn_timer
    import rxn_pkg::*;
#(
    parameter int PRESCALE_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       btn_n,
    output logic       led,
    output logic [3:0] digit_hi,
    output logic [3:0] digit_lo
);
    logic                           tick;
    run_t                           run;
    logic [N_DIGITS-1:0][BCD_W-1:0] count;
    bcd_pair_t                      shown;

    rxn_prescaler #(.PRESCALE_W(PRESCALE_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rxn_run_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (arm),
        .press (~btn_n),
        .run   (run)
    );

    rxn_bcd_counter #(.DIGITS(N_DIGITS)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .step  (tick & (run == RUN_ON)),
        .value (count)
    );

    assign shown.hi = count[1];
    assign shown.lo = count[0];

    assign led      = (run == RUN_ON);
    assign digit_hi = shown.hi;
    assign digit_lo = shown.lo;
endmodule

// File: rtl/rxn_timer_chk.sv
module rxn_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       arm,
    input logic       btn_n,
    input logic       led,
    input logic [3:0] digit_hi,
    input logic [3:0] digit_lo
);
    logic [6:0] bin;
    assign bin = {3'b0, digit_hi} * 7'd10 + {3'b0, digit_lo};

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!led && digit_hi == 4'd0 && digit_lo == 4'd0));

    a_r8_digits_bcd: assert property (@(posedge clk) disable iff (rst)
        (digit_hi <= 4'd9 && digit_lo <= 4'd9));

    a_r7_hold_at_max: assert property (@(posedge clk) disable iff (rst)
        (digit_hi == 4'd9 && digit_lo == 4'd9) |=> (digit_hi == 4'd9 && digit_lo == 4'd9));

    a_r4_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        !led |=> $stable({digit_hi, digit_lo}));

    a_r5_press_stops: assert property (@(posedge clk) disable iff (rst)
        (led && !btn_n) |=> !led);

    a_r6_stays_dark: assert property (@(posedge clk) disable iff (rst)
        (!led && !arm) |=> !led);

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        led |=> (bin == $past(bin) || bin == $past(bin) + 7'd1));
endmodule

bind rxn_timer rxn_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .btn_n    (btn_n),
    .led      (led),
    .digit_hi (digit_hi),
    .digit_lo (digit_lo)
);

// File: tb/rxn_timer_test.sv
module rxn_timer_test;
    localparam int PW     = 4;
    localparam int PERIOD = 1 << PW;
    localparam int NV     = 6;
    // stimulus: cycles between arm and press; expected: saturated at 99
    localparam int DELAY [NV] = '{0, 5, 40, 170, 800, 1700};
    localparam bit SAT   [NV] = '{0, 0, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic btn_n = 1'b1;
    logic led;
    logic [3:0] digit_hi, digit_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int  e      = 0;
    int  m_val  = 0;
    bit  m_run  = 0;
    bit  m_done = 0;

    always #2 clk = ~clk;

    rxn_timer #(.PRESCALE_W(PW)) uut (
        .clk(clk), .rst(rst), .arm(arm), .btn_n(btn_n),
        .led(led), .digit_hi(digit_hi), .digit_lo(digit_lo)
    );

    always @(posedge clk) begin
        if (rst) begin
            e <= 0; m_val <= 0; m_run <= 0; m_done <= 0;
        end else begin
            e <= e + 1;
            if (m_run && e > 0 && (e % PERIOD) == 0 && m_val < 99) m_val <= m_val + 1;
            if (m_run) begin
                if (!btn_n) begin m_run <= 0; m_done <= 1; end
            end else if (arm && !m_done) begin
                m_run <= 1;
            end
        end
    end

    task automatic chk(input string tag);
        checks++;
        if (led !== m_run || digit_hi !== 4'(m_val / 10) || digit_lo !== 4'(m_val % 10)) begin
            fails++;
            $display("FAIL %s: led=%0b digits=%0d%0d expected led=%0b digits=%0d%0d",
                     tag, led, digit_hi, digit_lo, m_run, m_val / 10, m_val % 10);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; arm = 1'b0; btn_n = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic pulse_arm();
        arm = 1'b1; step(1); arm = 1'b0;
    endtask

    task automatic push(input int n);
        btn_n = 1'b0; step(n); btn_n = 1'b1;
    endtask

    initial begin
        step(1);
        do_reset();
        chk("R1 reset state");

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            step(3);
            pulse_arm();
            chk("R2 arm lights led");
            step(DELAY[v]);
            chk("R3 R8 count while running");
            push(2);
            chk("R5 press stops");
            if (SAT[v] && !(digit_hi == 4'd9 && digit_lo == 4'd9)) begin
                fails++;
                $display("FAIL R7: digits=%0d%0d expected 99", digit_hi, digit_lo);
            end
            checks++;
            step(3 * PERIOD);
            chk("R5 count held after stop");
            pulse_arm();
            step(2 * PERIOD);
            chk("R9 arm ignored after stop");
        end

        // R6: press while idle, then arm still works
        do_reset();
        push(3 * PERIOD);
        chk("R6 idle press no effect");
        pulse_arm();
        step(PERIOD * 3);
        chk("R6 arm after idle press");
        if (digit_lo == 4'd0) begin
            fails++;
            $display("FAIL R3: digit_lo=%0d expected nonzero", digit_lo);
        end
        checks++;

        // R4: no counting while idle
        do_reset();
        step(4 * PERIOD);
        chk("R4 idle no count");

        // R10: press coinciding with tick
        do_reset();
        pulse_arm();
        step(2 * PERIOD);
        while (!(e > 0 && (e % PERIOD) == 0)) step(1);
        push(1);
        chk("R10 tick at press counted");
        step(2);
        chk("R10 frozen");

        // R1: reset mid-run clears
        do_reset();
        pulse_arm();
        step(5 * PERIOD);
        rst = 1'b1; step(1);
        chk("R1 reset mid run");
        rst = 1'b0; step(1);
        chk("R1 after release");

        // R8: carry across low digit
        do_reset();
        pulse_arm();
        step(11 * PERIOD + 3);
        chk("R8 carry into high digit");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule